// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Select

This block sits in the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value should come from. The operand can come from the value read out of the register file. It can also come from the result held one stage ahead, in the memory stage, or from the result held two stages ahead, in the writeback stage.

The block compares the two source register numbers of the instruction now in execute against the destination register numbers of the two older instructions. A producer counts only if it actually writes a register and that register is not register zero. When both older instructions write the source register, the younger one (the memory-stage instruction) wins, because it holds the most recent value.

The logic is purely combinational and holds no state. Its two 2-bit selects drive the operand multiplexers in front of the ALU.

Top module: `fwd_select`

## Requirements
- R1: Select encoding: 2'b00 picks the register file value, 2'b10 picks the memory-stage result and 2'b01 picks the writeback-stage result.
- R2: When the memory-stage write enable is 1, its destination is nonzero and it equals an operand's source register number, that operand's select is 2'b10.
- R3: When the writeback-stage write enable is 1, its destination is nonzero and it equals an operand's source number, and R2 does not apply to that operand, the select is 2'b01.
- R4: When both stages meet their match conditions for the same operand, the select is 2'b10, so the newest value is used.
- R5: A stage whose write enable is 0 never causes forwarding, whatever its destination number.
- R6: A destination register number of 0 never causes forwarding, even when the source number is also 0 and the write enable is 1.
- R7: Operand A is compared using src_a_idx and operand B using src_b_idx. The two selects are computed independently, and both may forward in the same cycle, from the same stage or from different stages.
- R8: The select value 2'b11 is never produced.
- R9: When neither stage matches an operand, its select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Source register number for ALU operand A, from the decode/execute register |
| src_b_idx | input | 5 | Source register number for ALU operand B, from the decode/execute register |
| mem_dst_idx | input | 5 | Destination register number of the memory-stage instruction |
| mem_wr_en | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst_idx | input | 5 | Destination register number of the writeback-stage instruction |
| wb_wr_en | input | 1 | Register write enable of the writeback-stage instruction |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |

## Verification
The block has no state, so any fault shows at the select outputs in the same cycle as the input combination that exposes it. There is no latency to hide a wrong decision. A wrong priority shows up only when both stages write the same nonzero register that a source names. A dropped qualifier shows up only when the write enable is low or the destination is zero, so the bench aims directed cases at each of those corners. It also crosses the two operands, so that one select taking the other operand's source number is caught.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a_idx,
  input  logic [REG_W-1:0] src_b_idx,
  input  logic [REG_W-1:0] mem_dst_idx,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst_idx,
  input  logic             wb_wr_en,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);

  localparam int          NUM_OPS = 2;
  localparam logic [1:0]  SEL_RF  = 2'b00;
  localparam logic [1:0]  SEL_MEM = 2'b10;
  localparam logic [1:0]  SEL_WB  = 2'b01;

  logic             mem_live;
  logic             wb_live;
  logic [REG_W-1:0] src_idx [NUM_OPS];
  logic [1:0]       sel     [NUM_OPS];

  assign mem_live   = mem_wr_en && (mem_dst_idx != '0);
  assign wb_live    = wb_wr_en  && (wb_dst_idx  != '0);

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic hit_mem;
    logic hit_wb;
    assign hit_mem = mem_live && (mem_dst_idx == src_idx[i]);
    assign hit_wb  = wb_live  && (wb_dst_idx  == src_idx[i]);
    assign sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];

endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] src_a_idx,
  input logic [REG_W-1:0] src_b_idx,
  input logic [REG_W-1:0] mem_dst_idx,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] wb_dst_idx,
  input logic             wb_wr_en,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b
);

  logic known;
  assign known = !$isunknown({src_a_idx, src_b_idx, mem_dst_idx, mem_wr_en,
                              wb_dst_idx, wb_wr_en, sel_a, sel_b});

  always_comb begin
    if (known) begin
      assert_no_code_three_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);
      if (sel_a == 2'b10)
        assert_a_mem_qualified_R2: assert (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_a_idx);
      if (sel_b == 2'b10)
        assert_b_mem_qualified_R2: assert (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_b_idx);
      if (sel_a == 2'b01)
        assert_a_wb_qualified_R3: assert (wb_wr_en && wb_dst_idx != '0 && wb_dst_idx == src_a_idx);
      if (sel_b == 2'b01)
        assert_b_wb_qualified_R3: assert (wb_wr_en && wb_dst_idx != '0 && wb_dst_idx == src_b_idx);
      if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_a_idx)
        assert_a_newest_wins_R4: assert (sel_a == 2'b10);
      if (mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_b_idx)
        assert_b_newest_wins_R4: assert (sel_b == 2'b10);
      if (!mem_wr_en && !wb_wr_en)
        assert_idle_stages_R5: assert (sel_a == 2'b00 && sel_b == 2'b00);
      if (src_a_idx == '0)
        assert_a_zero_src_R6: assert (sel_a == 2'b00);
      if (src_b_idx == '0)
        assert_b_zero_src_R6: assert (sel_b == 2'b00);
    end
  end

endmodule

bind fwd_select fwd_select_chk #(.REG_W(REG_W)) u_chk (
  .src_a_idx  (src_a_idx),
  .src_b_idx  (src_b_idx),
  .mem_dst_idx(mem_dst_idx),
  .mem_wr_en  (mem_wr_en),
  .wb_dst_idx (wb_dst_idx),
  .wb_wr_en   (wb_wr_en),
  .sel_a      (sel_a),
  .sel_b      (sel_b)
);

// File: tb/sim_fwd_select.sv
module sim_fwd_select;

  localparam int REG_W = 5;

  typedef struct {
    logic [1:0] exp_a;
    logic [1:0] exp_b;
    string      tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] src_a_idx = '0;
  logic [REG_W-1:0] src_b_idx = '0;
  logic [REG_W-1:0] mem_dst_idx = '0;
  logic             mem_wr_en = 1'b0;
  logic [REG_W-1:0] wb_dst_idx = '0;
  logic             wb_wr_en = 1'b0;
  logic [1:0]       sel_a;
  logic [1:0]       sel_b;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;

  always #10 clk = ~clk;

  fwd_select #(.REG_W(REG_W)) u0 (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en),
    .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] ref_sel(input logic [REG_W-1:0] src,
                                         input logic [REG_W-1:0] md, input logic mw,
                                         input logic [REG_W-1:0] wd, input logic ww);
    logic [1:0] r;
    r = 2'b00;
    if (ww && wd != 0 && wd == src) r = 2'b01;
    if (mw && md != 0 && md == src) r = 2'b10;
    return r;
  endfunction

  task automatic drive(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                       input logic [REG_W-1:0] md, input logic mw,
                       input logic [REG_W-1:0] wd, input logic ww, input string tag);
    item_t it;
    @(posedge clk);
    src_a_idx = sa; src_b_idx = sb;
    mem_dst_idx = md; mem_wr_en = mw;
    wb_dst_idx = wd; wb_wr_en = ww;
    it.exp_a = ref_sel(sa, md, mw, wd, ww);
    it.exp_b = ref_sel(sb, md, mw, wd, ww);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_fixed(input logic [1:0] ea, input logic [1:0] eb, input string tag);
    item_t it;
    @(posedge clk);
    it.exp_a = ea; it.exp_b = eb; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (sel_a !== it.exp_a || sel_b !== it.exp_b) begin
        n_fails++;
        $display("FAIL %s: sel_a=%b sel_b=%b expected sel_a=%b sel_b=%b",
                 it.tag, sel_a, sel_b, it.exp_a, it.exp_b);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9 R1: idle inputs give register file select 00 for both
    expect_fixed(2'b00, 2'b00, "R9 idle after reset");
    // R2 R1: memory stage hit on A only -> 10
    drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, "R2 mem hit A");
    expect_fixed(2'b10, 2'b00, "R2 mem hit A fixed encoding 10");
    // R3 R1: writeback hit on B only -> 01
    drive(5'd7, 5'd9, 5'd0, 1'b0, 5'd9, 1'b1, "R3 wb hit B");
    expect_fixed(2'b00, 2'b01, "R3 wb hit B fixed encoding 01");
    // R4: both stages write same register
    drive(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, "R4 both stages, both ops");
    expect_fixed(2'b10, 2'b10, "R4 newest wins fixed");
    // R5: write enables low
    drive(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0, "R5 both enables low");
    expect_fixed(2'b00, 2'b00, "R5 enables low fixed");
    drive(5'd6, 5'd8, 5'd6, 1'b0, 5'd6, 1'b1, "R5 mem disabled falls to wb");
    expect_fixed(2'b01, 2'b00, "R5 mem disabled fixed");
    // R6: register zero never forwarded
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R6 zero dest");
    expect_fixed(2'b00, 2'b00, "R6 zero dest fixed");
    drive(5'd0, 5'd2, 5'd0, 1'b1, 5'd2, 1'b1, "R6 zero mem dest, wb for B");
    expect_fixed(2'b00, 2'b01, "R6 wb for B fixed");
    // R7: independent operands, different sources
    drive(5'd10, 5'd20, 5'd20, 1'b1, 5'd10, 1'b1, "R7 A from wb, B from mem");
    expect_fixed(2'b01, 2'b10, "R7 cross fixed");
    drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd5, 1'b1, "R7 both from mem");
    // R9: no match
    drive(5'd11, 5'd12, 5'd13, 1'b1, 5'd14, 1'b1, "R9 no match");
    expect_fixed(2'b00, 2'b00, "R9 no match fixed");
    // R8 R7: sweep with small register numbers to hit many collisions
    for (int k = 0; k < 1500; k++) begin
      logic [REG_W-1:0] v [4];
      for (int j = 0; j < 4; j++) v[j] = REG_W'($urandom_range(0, 3));
      drive(v[0], v[1], v[2], 1'($urandom), v[3], 1'($urandom), "R7 R8 sweep");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule